// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the array address for each beat of a short burst in a pipelined synchronous memory. On a load cycle it captures the full external address together with the access type (read or write). On each following advance cycle it leaves the upper address bits fixed. It produces the next low-order bits in one of two orders: a plain count that wraps inside the aligned block, or an order in which each beat is the starting low bits XORed with the beat number. A static mode pin chooses the order. A clock enable freezes all state, so a stalled cycle neither loads nor steps.

The access type captured on the load cycle is driven alongside the address for the whole burst. Downstream write and read paths therefore stay consistent with the type chosen at the start, whatever the type input does later. The burst length is 2^BEAT_W beats (four by default). Command decoding and the storage array sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first load, addr_o is all zeros and wr_o is 0.
- R2: On a rising edge with en_i=1 and adv_i=0 (load), addr_o takes the value of addr_i and wr_o the value of wr_i, visible right after that edge.
- R3: On a rising edge with en_i=1 and adv_i=1 (advance), addr_i is ignored and the address bits above the low BEAT_W bits keep their loaded value.
- R4: With mode_i=0 (linear), each advance makes the low BEAT_W bits of addr_o one more than before, modulo 2^BEAT_W, with no carry into the upper bits.
- R5: With mode_i=1 (interleaved), the low BEAT_W bits on beat k equal the loaded low bits XOR k, where k is the number of advances since the load.
- R6: After the last beat of a burst, further advances repeat the same 2^BEAT_W addresses in the same order until the next load.
- R7: On a rising edge with en_i=0, addr_o and wr_o do not change, whether adv_i calls for a load or an advance.
- R8: During advance cycles wr_i is ignored and wr_o keeps the type latched on the load cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; 0 stalls the sequencer |
| adv_i | input | 1 | 0 = load external address, 1 = advance burst |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_i | input | ADDR_W | External start address |
| wr_i | input | 1 | Access type for a new burst, 1 = write |
| addr_o | output | ADDR_W | Array address for the current beat |
| wr_o | output | 1 | Access type latched at the start of the burst |

## Verification
A corrupted beat counter shows on the low address bits in the cycle after the fault. It shows as a skipped or repeated word in linear order, or as a wrong XOR partner in interleaved order. A base register that is wrongly overwritten shows as a jump in the upper bits during an advance. A type register that is wrongly overwritten shows as a wr_o flip in mid-burst. Both appear one edge after the offending cycle. A stall that leaks through shows as an address step across a cycle with en_i low. The bench therefore runs bursts past their wrap point in both orders, from starting offsets other than zero, with stalls and conflicting inputs placed inside the bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic {
    CMD_LOAD = 1'b0,
    CMD_ADV  = 1'b1
  } burst_cmd_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  import burst_seq_pkg::*;

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     beat_q <= '0;
    else if (en_i) begin
      if (burst_cmd_e'(adv_i) == CMD_ADV) beat_q <= beat_q + 1'b1; // wraps at 2^BEAT_W
      else                           beat_q <= '0;
    end
  end

  assign beat_o = beat_q;

  assert_beat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(beat_q));

  assert_beat_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> (beat_q == '0));

  assert_beat_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && (beat_q == '1)) |=> (beat_q == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              wr_o
);
  logic [ADDR_W-1:0] base_q;
  logic              wr_q;
  logic              load;

  assign load = en_i & ~adv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      wr_q   <= 1'b0;
    end else if (load) begin
      base_q <= addr_i;
      wr_q   <= wr_i;
    end
  end

  assign base_o = base_q;
  assign wr_o   = wr_q;

  assert_base_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> (base_q == $past(addr_i)) && (wr_q == $past(wr_i)));

  assert_base_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> $stable(base_q));

  assert_type_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i || !en_i) |=> $stable(wr_q));
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              mode_i,
  output logic [BEAT_W-1:0] lo_o
);
  import burst_seq_pkg::*;

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start_i + beat_i; // modulo 2^BEAT_W
  assign xor_lo = start_i ^ beat_i;

  always_comb begin
    unique case (burst_order_e'(mode_i))
      ORD_XOR: lo_o = xor_lo;
      default: lo_o = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .adv_i (adv_i),
    .addr_i(addr_i),
    .wr_i  (wr_i),
    .base_o(base),
    .wr_o  (wr_o)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .adv_i (adv_i),
    .beat_o(beat)
  );

  burst_order #(.BEAT_W(BEAT_W)) u_order (
    .start_i(base[BEAT_W-1:0]),
    .beat_i (beat),
    .mode_i (mode_i),
    .lo_o   (lo)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], lo};

  logic [BEAT_W-1:0] out_lo;
  logic [HI_W-1:0]   out_hi;
  assign out_lo = addr_o[BEAT_W-1:0];
  assign out_hi = addr_o[ADDR_W-1:BEAT_W];

  assert_hi_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> $stable(out_hi));

  assert_lin_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && !mode_i) |=> mode_i || (out_lo == BEAT_W'($past(out_lo) + 1'b1)));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $stable(mode_i)) |=> $stable(addr_o) && $stable(wr_o));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 19;
  localparam int BEAT_W = 2;
  localparam int NV     = 14;

  typedef struct packed {
    logic              en;
    logic              adv;
    logic              mode;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] exp_addr;
    logic              exp_wr;
    logic [3:0]        req;
  } vec_t;

  // Each entry: inputs for one edge, then outputs expected after it.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 19'h12345, 19'h12345, 1'b1, 4'd2}, // R2 load linear
    '{1'b1, 1'b1, 1'b0, 1'b0, 19'h7FFFF, 19'h12346, 1'b1, 4'd3}, // R3 addr/wr ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 19'h00000, 19'h12347, 1'b1, 4'd4}, // R4
    '{1'b1, 1'b1, 1'b0, 1'b0, 19'h00000, 19'h12344, 1'b1, 4'd4}, // R4 wrap in block
    '{1'b1, 1'b1, 1'b0, 1'b0, 19'h00000, 19'h12345, 1'b1, 4'd6}, // R6 repeat
    '{1'b0, 1'b1, 1'b0, 1'b0, 19'h00000, 19'h12345, 1'b1, 4'd7}, // R7 stalled advance
    '{1'b0, 1'b0, 1'b0, 1'b0, 19'h00ABC, 19'h12345, 1'b1, 4'd7}, // R7 stalled load
    '{1'b1, 1'b0, 1'b1, 1'b0, 19'h00ABE, 19'h00ABE, 1'b0, 4'd2}, // R2 load interleaved
    '{1'b1, 1'b1, 1'b1, 1'b1, 19'h55555, 19'h00ABF, 1'b0, 4'd5}, // R5 10^01
    '{1'b1, 1'b1, 1'b1, 1'b1, 19'h00000, 19'h00ABC, 1'b0, 4'd5}, // R5 10^10
    '{1'b1, 1'b1, 1'b1, 1'b1, 19'h00000, 19'h00ABD, 1'b0, 4'd8}, // R8 10^11, type held
    '{1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 19'h00ABE, 1'b0, 4'd6}, // R6 back to start
    '{1'b1, 1'b0, 1'b0, 1'b1, 19'h00003, 19'h00003, 1'b1, 4'd2}, // R2 load low=11
    '{1'b1, 1'b1, 1'b0, 1'b0, 19'h00000, 19'h00000, 1'b1, 4'd4}  // R4 no carry up
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              wr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .adv_i (adv_i),
    .mode_i(mode_i),
    .addr_i(addr_i),
    .wr_i  (wr_i),
    .addr_o(addr_o),
    .wr_o  (wr_o)
  );

  task automatic check(input int req, input logic [ADDR_W-1:0] exp_a, input logic exp_w);
    n_chk++;
    if (addr_o !== exp_a || wr_o !== exp_w) begin
      n_fail++;
      $display("FAIL R%0d: addr_o=%h wr_o=%b, expected addr_o=%h wr_o=%b",
               req, addr_o, wr_o, exp_a, exp_w);
    end
  endtask

  task automatic drive(input logic en, input logic adv, input logic mode,
                       input logic wr, input logic [ADDR_W-1:0] a);
    en_i = en; adv_i = adv; mode_i = mode; wr_i = wr; addr_i = a;
    @(negedge clk_i);
  endtask

  initial begin
    // R1: held in reset with a load pending
    en_i = 1'b1; adv_i = 1'b0; wr_i = 1'b1; addr_i = 19'h3FFFF;
    repeat (3) @(negedge clk_i);
    check(1, '0, 1'b0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, '0, 1'b0); // R1 after release, no load yet

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].en, VEC[i].adv, VEC[i].mode, VEC[i].wr, VEC[i].addr);
      check(int'(VEC[i].req), VEC[i].exp_addr, VEC[i].exp_wr);
    end

    // R6: eight advances in linear order from low=10 return to the start twice
    drive(1'b1, 1'b0, 1'b0, 1'b0, 19'h40002);
    for (int k = 1; k <= 8; k++) begin
      drive(1'b1, 1'b1, 1'b0, 1'b1, 19'h7FFFF);
      check(6, {17'h10000, 2'(2 + k)}, 1'b0);
    end

    // R7: stall inside an interleaved burst, then resume
    drive(1'b1, 1'b0, 1'b1, 1'b1, 19'h00101);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 19'h0);      // beat1: 01^01=00
    check(5, 19'h00100, 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 19'h0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 19'h7FFFF);
    check(7, 19'h00100, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 19'h0);      // beat2: 01^10=11
    check(5, 19'h00103, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 19'h0);      // beat3: 01^11=10
    check(8, 19'h00102, 1'b1);

    // R1: reset in mid-burst clears outputs
    rst_ni = 1'b0;
    #3;
    check(1, '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    en_i = 1'b0;
    @(negedge clk_i);
    check(1, '0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule